// File: doc/BRIEF.md
# Multi-Channel Frame-Based PWM Bank

This block holds a small group of independent pulse-width outputs, each configured through byte-wide registers on a plain write/read strobe interface. Each channel divides the reference clock into time quanta. The length of a quantum is set by a 4-bit frequency code F and equals 32 − F clock cycles, so a quantum lasts between 17 and 32 cycles. Every output frame is exactly 1024 quanta long. The high portion at the start of the frame lasts D + 1 quanta, where D is a 10-bit duty value. The duty therefore runs from one quantum up to the whole frame and can never be zero.

A shared enable register turns each channel on or off. A channel that is off drives its output low. Turning a channel on starts a fresh frame with the output high. Duty and frequency changes written while a frame is running are held back until the next frame begins, so the output never shows a shortened or split pulse. At the nominal 9.6 MHz reference, the frame rate spans roughly 293 Hz (F = 0) to 551 Hz (F = 15).

Top module: `pwm_bank`

## Requirements
- R1: After synchronous active-high reset, every register reads 0x00 and every output is low.
- R2: Channel n owns two registers. Offset 0x60+2n holds D[7:0]. Offset 0x61+2n holds D[9:8] in bits [1:0] and F in bits [7:4]. Offset 0x66 is the enable register, with bit n enabling channel n. A read of any other offset returns 0x00.
- R3: A read returns the value last written. Bits [3:2] of the second register of each pair read 0. Enable bits at or above the channel count read 0.
- R4: While a channel is enabled, its output is high for (D+1)·(32−F) clock cycles at the start of each frame.
- R5: Each frame lasts exactly 1024·(32−F) clock cycles, whatever the value of D.
- R6: D or F written during a frame changes nothing in that frame; the new values take effect at the start of the next frame.
- R7: A write that sets a channel's enable bit makes its output go high after the second rising clock edge that follows the write edge, and a fresh frame begins at that point.
- R8: A write that clears a channel's enable bit drives its output low after the second rising edge and holds it low for as long as the bit stays clear.
- R9: With D = 1023 the output stays high continuously, including across frame boundaries.
- R10: Each channel runs from its own settings, independent of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0 when rd_en is low |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
Two channels run at the same time: one with the shortest quantum (F = 15) and a short pulse, the other with the longest quantum (F = 0) and the minimum one-quantum pulse. Measuring both pulse widths and gaps shows that the quantum length, the duty offset by one and the period each follow their own channel's settings. A duty write made in the middle of a high phase must leave that pulse unchanged and lengthen only the next one, which separates the buffered update from an immediate one. A full-scale duty setting, a disable and a re-enable after a gap then cover the continuous-high case, the forced-low case and the restart of the frame counter.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DUTY_W  = 10;
    localparam int FCODE_W = 4;
    localparam int DIV_W   = FCODE_W + 1;

    typedef struct packed {
        logic [DUTY_W-1:0]  duty;
        logic [FCODE_W-1:0] fcode;
    } chan_cfg_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int BASE_ADDR = 'h60,
    parameter int EN_ADDR   = 'h66
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [7:0]             addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output chan_cfg_t [NUM_CH-1:0] cfg,
    output logic [NUM_CH-1:0]      en_bits
);

    localparam logic [7:0] EN_A = 8'(EN_ADDR);

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
        logic [NUM_CH-1:0]      en;
    } regs_t;

    regs_t      regs_d, regs_q;
    logic [7:0] rdata_d;

    always_comb begin
        regs_d  = regs_q;
        rdata_d = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en && addr == 8'(BASE_ADDR + 2*i)) begin
                regs_d.cfg[i].duty[7:0] = wdata;
            end
            if (wr_en && addr == 8'(BASE_ADDR + 2*i + 1)) begin
                regs_d.cfg[i].duty[DUTY_W-1:8] = wdata[1:0];
                regs_d.cfg[i].fcode            = wdata[7:4];
            end
            if (rd_en && addr == 8'(BASE_ADDR + 2*i)) begin
                rdata_d = regs_q.cfg[i].duty[7:0];
            end
            if (rd_en && addr == 8'(BASE_ADDR + 2*i + 1)) begin
                rdata_d = {regs_q.cfg[i].fcode, 2'b00, regs_q.cfg[i].duty[DUTY_W-1:8]};
            end
        end
        if (wr_en && addr == EN_A) begin
            regs_d.en = wdata[NUM_CH-1:0];
        end
        if (rd_en && addr == EN_A) begin
            rdata_d = 8'(regs_q.en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata   = rdata_d;
    assign en_bits = regs_q.en;
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
        assign cfg[g] = regs_q.cfg[g];
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  chan_cfg_t         cfg,
    output logic              pwm,
    output logic [DUTY_W-1:0] frame_pos,
    output logic [DUTY_W-1:0] act_duty
);

    localparam logic [DUTY_W-1:0] LAST_Q = '1;

    typedef struct packed {
        logic              en;
        logic [DIV_W-1:0]  pre;
        logic [DIV_W-1:0]  div_m1;
        logic [DUTY_W-1:0] frm;
        logic [DUTY_W-1:0] duty;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [DIV_W-1:0] new_div_m1;

    // quantum = 32 - F cycles, so the terminal prescaler count is 31 - F
    assign new_div_m1 = 5'd31 - {1'b0, cfg.fcode};

    always_comb begin
        st_d    = st_q;
        st_d.en = en;
        if (!en) begin
            st_d.pre = '0;
            st_d.frm = '0;
        end else if (!st_q.en) begin
            st_d.pre    = '0;
            st_d.frm    = '0;
            st_d.duty   = cfg.duty;
            st_d.div_m1 = new_div_m1;
        end else if (st_q.pre == st_q.div_m1) begin
            st_d.pre = '0;
            st_d.frm = st_q.frm + 1'b1;
            if (st_q.frm == LAST_Q) begin
                st_d.duty   = cfg.duty;
                st_d.div_m1 = new_div_m1;
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm       = st_q.en && (st_q.frm <= st_q.duty);
    assign frame_pos = st_q.frm;
    assign act_duty  = st_q.duty;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int BASE_ADDR = 'h60,
    parameter int EN_ADDR   = 'h66
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t [NUM_CH-1:0]     cfg;
    logic [NUM_CH-1:0]          en_bits;
    logic [NUM_CH*DUTY_W-1:0]   frame_flat;
    logic [NUM_CH*DUTY_W-1:0]   duty_flat;

    pwm_regs #(
        .NUM_CH   (NUM_CH),
        .BASE_ADDR(BASE_ADDR),
        .EN_ADDR  (EN_ADDR)
    ) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .cfg    (cfg),
        .en_bits(en_bits)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel i_chan (
            .clk      (clk),
            .rst      (rst),
            .en       (en_bits[g]),
            .cfg      (cfg[g]),
            .pwm      (pwm_out[g]),
            .frame_pos(frame_flat[g*DUTY_W +: DUTY_W]),
            .act_duty (duty_flat[g*DUTY_W +: DUTY_W])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NUM_CH    = 3,
    parameter int BASE_ADDR = 'h60,
    parameter int EN_ADDR   = 'h66
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_en,
    input logic [7:0]           addr,
    input logic [7:0]           rdata,
    input logic [NUM_CH-1:0]    en_bits,
    input logic [NUM_CH-1:0]    pwm_out,
    input logic [NUM_CH*10-1:0] frame_flat,
    input logic [NUM_CH*10-1:0] duty_flat
);

    logic hi_sel;
    always_comb begin
        hi_sel = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == 8'(BASE_ADDR + 2*i + 1)) hi_sel = 1'b1;
        end
    end

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && hi_sel) |-> (rdata[3:2] == 2'b00));

    // R3
    en_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'(EN_ADDR)) |-> ((rdata >> NUM_CH) == 8'h00));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R8
        disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
            $past(!en_bits[g]) |-> !pwm_out[g]);

        // R7
        enable_start_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(en_bits[g]) |=> pwm_out[g]);

        // R6
        duty_swap_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(duty_flat[g*10 +: 10]) |-> (frame_flat[g*10 +: 10] == 10'd0));

        // R9
        full_duty_chk: assert property (@(posedge clk) disable iff (rst)
            (en_bits[g] && $past(en_bits[g]) && duty_flat[g*10 +: 10] == 10'h3FF)
            |-> pwm_out[g]);
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH   (NUM_CH),
    .BASE_ADDR(BASE_ADDR),
    .EN_ADDR  (EN_ADDR)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .en_bits   (en_bits),
    .pwm_out   (pwm_out),
    .frame_flat(frame_flat),
    .duty_flat (duty_flat)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [7:0]     addr = '0;
    logic [7:0]     wdata = '0;
    logic [7:0]     rdata;
    logic [NCH-1:0] pwm_out;

    pwm_bank #(.NUM_CH(NCH)) i_pwm_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    len;
        string tag;
    } item_t;

    item_t q0[$];
    item_t q1[$];
    bit    skip0 = 1'b0;
    bit    skip1 = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(tag, int'(rdata), exp);
        rd_en = 1'b0;
    endtask

    task automatic push0(int len, string tag);
        item_t it;
        it.len = len; it.tag = tag;
        q0.push_back(it);
    endtask

    task automatic push1(int len, string tag);
        item_t it;
        it.len = len; it.tag = tag;
        q1.push_back(it);
    endtask

    // monitors: measure each completed level segment and compare with the queue
    int   cnt0 = 0;
    logic lvl0 = 1'b0;
    always @(negedge clk) begin
        item_t it;
        if (!rst) begin
            if (pwm_out[0] !== lvl0) begin
                if (skip0) skip0 = 1'b0;
                else if (q0.size() > 0) begin
                    it = q0.pop_front();
                    check(it.tag, cnt0, it.len);
                end
                cnt0 = 1;
                lvl0 = pwm_out[0];
            end else begin
                cnt0++;
            end
        end
    end

    int   cnt1 = 0;
    logic lvl1 = 1'b0;
    always @(negedge clk) begin
        item_t it;
        if (!rst) begin
            if (pwm_out[1] !== lvl1) begin
                if (skip1) skip1 = 1'b0;
                else if (q1.size() > 0) begin
                    it = q1.pop_front();
                    check(it.tag, cnt1, it.len);
                end
                cnt1 = 1;
                lvl1 = pwm_out[1];
            end else begin
                cnt1++;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int lows;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 'h60; a <= 'h66; a++) rd_chk(8'(a), 0, "R1 reg after reset");
        check("R1 outputs after reset", int'(pwm_out), 0);

        // R2 / R3: map and readback
        wr(8'h64, 8'hA5);
        rd_chk(8'h64, 'hA5, "R2 ch2 duty low byte");
        wr(8'h65, 8'hFF);
        rd_chk(8'h65, 'hF3, "R3 reserved bits of second reg");
        wr(8'h66, 8'hFF);
        rd_chk(8'h66, 'h07, "R3 unused enable bits");
        wr(8'h66, 8'h00);
        rd_chk(8'h67, 0, "R2 unmapped offset");

        // ch0: D=9 F=15 (17-cycle quantum); ch1: D=0 F=0 (32-cycle quantum)
        wr(8'h60, 8'h09);
        wr(8'h61, 8'hF0);
        wr(8'h62, 8'h00);
        wr(8'h63, 8'h00);
        rd_chk(8'h61, 'hF0, "R2 ch0 second reg");
        push0(170, "R4 ch0 high D=9 F=15");
        push0(17238, "R5 ch0 low D=9 F=15");
        push0(170, "R6 ch0 high unchanged by mid-frame write");
        push0(17238, "R5 ch0 low second frame");
        push0(340, "R6 ch0 high after buffered D=19");
        push0(17068, "R5 ch0 low with D=19");
        push1(32, "R10 ch1 high D=0 F=0");
        push1(32736, "R10 ch1 low D=0 F=0");
        skip0 = 1'b1;
        skip1 = 1'b1;
        wr(8'h66, 8'h03);

        wait (pwm_out[0] == 1'b1);
        wait (pwm_out[0] == 1'b0);
        wait (pwm_out[0] == 1'b1);
        repeat (50) @(negedge clk);
        wr(8'h60, 8'd19);                  // R6 mid-frame write
        wait (pwm_out[0] == 1'b0);
        wait (pwm_out[0] == 1'b1);
        wait (pwm_out[0] == 1'b0);
        repeat (100) @(negedge clk);
        wr(8'h60, 8'hFF);
        wr(8'h61, 8'hF3);
        rd_chk(8'h61, 'hF3, "R3 ch0 second reg readback");

        // R9: continuous high across the frame boundary
        wait (pwm_out[0] == 1'b1);
        lows = 0;
        for (int k = 0; k < 17500; k++) begin
            @(negedge clk);
            if (pwm_out[0] !== 1'b1) lows++;
        end
        check("R9 low samples with D=1023", lows, 0);

        // R8: disable
        wr(8'h66, 8'h02);
        check("R8 ch0 still high one edge after write", int'(pwm_out[0]), 1);
        @(negedge clk);
        check("R8 ch0 low after disable", int'(pwm_out[0]), 0);
        lows = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (pwm_out[0] === 1'b0) lows++;
        end
        check("R8 ch0 held low while disabled", lows, 200);

        // R7: re-enable starts a fresh frame
        wr(8'h60, 8'h03);
        wr(8'h61, 8'hF0);
        push0(68, "R7 ch0 fresh-frame high D=3");
        skip0 = 1'b1;
        wr(8'h66, 8'h03);
        check("R7 ch0 low one edge after enable", int'(pwm_out[0]), 0);
        @(negedge clk);
        check("R7 ch0 high two edges after enable", int'(pwm_out[0]), 1);
        wait (pwm_out[0] == 1'b0);
        repeat (5) @(negedge clk);
        check("R4 all expected ch0 segments seen", q0.size(), 0);
        check("R10 all expected ch1 segments seen", q1.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule